// File: doc/BRIEF.md
# Event Counters and Interrupt Controller

This block gathers single-cycle event pulses from the surrounding datapath and control logic. It keeps two saturating occurrence counters, one for clipped (overrange) samples and one for input parity errors. It also holds a bank of sticky flags, one per event source, that software can mask and acknowledge over a simple register bus. Any flag that is set while its enable is set pulls a shared active-low interrupt line. Detecting the events themselves is left to the logic that produces the pulses.

Software enables the sources it cares about at address 0x03. When the interrupt line falls, software reads the flags at 0x04 and the counts at 0x01 and 0x02. It then acknowledges by writing ones to the flags it handled. Acknowledging the saturation flag or the parity flag also zeroes the matching counter, so one write both re-arms the interrupt and restarts the measurement.

Top module: `evt_irq_ctrl`

## Requirements
- R1: During and after a synchronous active-high reset, both counters, the enable register and all flags are 0, and `irq_n` is 1.
- R2: Each cycle with `evt_pulse[1]` high (saturation event) adds one to the counter read at address 0x01. The counter stops at 255 and never wraps.
- R3: Each cycle with `evt_pulse[7]` high (parity event) adds one to the counter read at address 0x02. It uses the same saturating rule.
- R4: Address 0x03 is a read/write enable register. Bit k (k = 1..7) enables source `evt_pulse[k]`. Bit 0 always reads 0 and ignores writes.
- R5: A pulse on `evt_pulse[k]` while enable bit k is 1 sets bit k of the flag register at address 0x04. A pulse on a disabled source leaves its flag unchanged.
- R6: A flag stays set until a write to 0x04 carries a 1 in its bit position. Writing 0 to a bit has no effect on it.
- R7: Writing 1 to bit 1 of 0x04 zeroes the saturation counter, and writing 1 to bit 7 zeroes the parity counter. Writing 1 to any other flag bit changes neither counter.
- R8: `irq_n` is 0 exactly while some flag and its enable bit are both 1. It returns to 1 once those flags are cleared or their enables are removed.
- R9: If a source pulses in the same cycle that its flag is cleared, the flag stays set (when enabled). A counted source's counter restarts at 1.
- R10: Writes to 0x01 and 0x02 change nothing, and reads from any address other than 0x01 to 0x04 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 7 ([7:1]) | One-cycle event pulses; index k is flag bit k |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | ADDR_W (8) | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational from state |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its defaults: 8-bit counters and an 8-bit address. With these values the 255 ceiling is reached by holding the saturation pulse high for 260 cycles, which exercises both the increment and the hold-at-top paths. The 8-bit address also allows a read of an unmapped location. The scoreboard also aims events and acknowledge writes at the same edge, which exercises the event-wins ordering on both a flag and a counter.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int REG_W = 8;

    localparam logic [REG_W-1:0] ADDR_SATCNT = 8'h01;
    localparam logic [REG_W-1:0] ADDR_PARCNT = 8'h02;
    localparam logic [REG_W-1:0] ADDR_IRQEN  = 8'h03;
    localparam logic [REG_W-1:0] ADDR_IRQST  = 8'h04;

    // flag positions with an attached counter
    localparam int SAT_BIT = 1;
    localparam int PAR_BIT = 7;

    // bit 0 of enable / flag registers is not implemented
    localparam logic [REG_W-1:0] LIVE_MASK = 8'hFE;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SAT,
        SEL_PAR,
        SEL_EN,
        SEL_ST
    } reg_sel_e;

    typedef struct packed {
        logic             wr;
        logic [REG_W-1:0] wdata;
        reg_sel_e         sel;
    } reg_req_t;

    function automatic logic [REG_W-1:0] keep_live(input logic [REG_W-1:0] v);
        return v & LIVE_MASK;
    endfunction

endpackage

// File: rtl/evt_sat_counter.sv
module evt_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= inc ? ONE : '0;
        end else if (inc && (cnt_q != TOP)) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign count = cnt_q;

    a_r2_hold_at_top: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == TOP && !clr) |=> (cnt_q == TOP));
    a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + ONE));
    a_r7_clear_zero: assert property (@(posedge clk) disable iff (rst)
        (clr && !inc) |=> (cnt_q == '0));
    a_r9_clear_restart: assert property (@(posedge clk) disable iff (rst)
        (clr && inc) |=> (cnt_q == ONE));

endmodule

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
    parameter int          N        = 8,
    parameter logic [N-1:0] LIVE    = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        if (LIVE[i]) begin : g_live
            logic q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= 1'b0;
                else if (set[i])
                    q <= 1'b1;
                else if (clr[i])
                    q <= 1'b0;
            end
            assign flags[i] = q;

            a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
                (q && !clr[i]) |=> q);
            a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
                (clr[i] && !set[i]) |=> !q);
            a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
                set[i] |=> q);
        end else begin : g_dead
            logic unused_in;
            assign unused_in = set[i] | clr[i];
            assign flags[i]  = 1'b0;
        end
    end

endmodule

// File: rtl/evt_reg_map.sv
module evt_reg_map
    import evt_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [CNT_W-1:0]  sat_cnt,
    input  logic [CNT_W-1:0]  par_cnt,
    input  logic [REG_W-1:0]  en_val,
    input  logic [REG_W-1:0]  st_val,
    output logic              en_we,
    output logic [REG_W-1:0]  en_wdata,
    output logic [REG_W-1:0]  ack_mask,
    output logic [REG_W-1:0]  reg_rdata
);
    reg_req_t req;

    always_comb begin
        req.wr    = reg_wr;
        req.wdata = reg_wdata;
        if (reg_addr == ADDR_W'(ADDR_SATCNT))
            req.sel = SEL_SAT;
        else if (reg_addr == ADDR_W'(ADDR_PARCNT))
            req.sel = SEL_PAR;
        else if (reg_addr == ADDR_W'(ADDR_IRQEN))
            req.sel = SEL_EN;
        else if (reg_addr == ADDR_W'(ADDR_IRQST))
            req.sel = SEL_ST;
        else
            req.sel = SEL_NONE;
    end

    assign en_we    = req.wr && (req.sel == SEL_EN);
    assign en_wdata = keep_live(req.wdata);
    assign ack_mask = (req.wr && req.sel == SEL_ST) ? keep_live(req.wdata) : '0;

    always_comb begin
        unique case (req.sel)
            SEL_SAT: reg_rdata = REG_W'(sat_cnt);
            SEL_PAR: reg_rdata = REG_W'(par_cnt);
            SEL_EN:  reg_rdata = en_val;
            SEL_ST:  reg_rdata = st_val;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:1]        evt_pulse,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_n
);
    logic [REG_W-1:0] ev_vec;
    logic [REG_W-1:0] en_q;
    logic [REG_W-1:0] flags;
    logic [REG_W-1:0] ack_mask;
    logic [REG_W-1:0] en_wdata;
    logic             en_we;
    logic [CNT_W-1:0] sat_cnt;
    logic [CNT_W-1:0] par_cnt;

    assign ev_vec = {evt_pulse, 1'b0};

    // enable register, bit 0 never stored (R4)
    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (en_we)
            en_q <= en_wdata;
    end

    evt_reg_map #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_map (
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .sat_cnt  (sat_cnt),
        .par_cnt  (par_cnt),
        .en_val   (en_q),
        .st_val   (flags),
        .en_we    (en_we),
        .en_wdata (en_wdata),
        .ack_mask (ack_mask),
        .reg_rdata(reg_rdata)
    );

    // sticky flags: enabled events set, W1C clears (R5, R6, R9)
    evt_flag_bank #(.N(REG_W), .LIVE(LIVE_MASK)) u_flags (
        .clk  (clk),
        .rst  (rst),
        .set  (ev_vec & en_q),
        .clr  (ack_mask),
        .flags(flags)
    );

    // saturation counter (R2) and parity counter (R3)
    evt_sat_counter #(.W(CNT_W)) u_sat_cnt (
        .clk  (clk),
        .rst  (rst),
        .inc  (ev_vec[SAT_BIT]),
        .clr  (ack_mask[SAT_BIT]),
        .count(sat_cnt)
    );

    evt_sat_counter #(.W(CNT_W)) u_par_cnt (
        .clk  (clk),
        .rst  (rst),
        .inc  (ev_vec[PAR_BIT]),
        .clr  (ack_mask[PAR_BIT]),
        .count(par_cnt)
    );

    assign irq_n = ~|(flags & en_q);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (irq_n && flags == '0 && en_q == '0));
    a_r5_enabled_event_irq: assert property (@(posedge clk) disable iff (rst)
        (|(ev_vec & en_q)) |=> !irq_n);
    a_r4_bit0_dead: assert property (@(posedge clk) disable iff (rst)
        en_we |=> (en_q[0] == 1'b0));
    a_r10_counters_ro: assert property (@(posedge clk) disable iff (rst)
        (!ev_vec[SAT_BIT] && !ack_mask[SAT_BIT]) |=> $stable(sat_cnt));
    a_r3_par_ro: assert property (@(posedge clk) disable iff (rst)
        (!ev_vec[PAR_BIT] && !ack_mask[PAR_BIT]) |=> $stable(par_cnt));

endmodule

// File: tb/evt_irq_ctrl_tb_top.sv
module evt_irq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] ev8 = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_n;

    always #10 clk = ~clk;

    evt_irq_ctrl dut_i (
        .clk      (clk),
        .rst      (rst),
        .evt_pulse(ev8[7:1]),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq_n    (irq_n)
    );

    typedef struct {
        bit         is_irq;
        logic [7:0] exp;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    event mon_ev;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(mon_ev);
            while (sb_q.size() > 0) begin
                exp_t       it;
                logic [7:0] got;
                it  = sb_q.pop_front();
                got = it.is_irq ? {7'b0, irq_n} : reg_rdata;
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s: got %02h expected %02h", it.tag, got, it.exp);
                end
            end
        end
    end

    task automatic exp_reg(input logic [7:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        reg_addr = a;
        #1;
        it.is_irq = 0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        ->mon_ev;
        #1;
    endtask

    task automatic exp_irq(input logic e, input string tag);
        exp_t it;
        @(negedge clk);
        #1;
        it.is_irq = 1; it.exp = {7'b0, e}; it.tag = tag;
        sb_q.push_back(it);
        ->mon_ev;
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic pulse(input logic [7:0] m, input int n);
        @(negedge clk);
        ev8 = m;
        repeat (n) @(negedge clk);
        ev8 = '0;
    endtask

    task automatic wr_with_evt(input logic [7:0] a, input logic [7:0] d, input logic [7:0] m);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d; ev8 = m;
        @(negedge clk);
        reg_wr = 0; ev8 = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset state
        exp_reg(8'h01, 8'h00, "R1 sat count");
        exp_reg(8'h02, 8'h00, "R1 par count");
        exp_reg(8'h03, 8'h00, "R1 enable");
        exp_reg(8'h04, 8'h00, "R1 flags");
        exp_irq(1'b1, "R1 irq_n");

        // R4 enable register, bit 0 dead
        wr(8'h03, 8'hFF);
        exp_reg(8'h03, 8'hFE, "R4 write ff");
        wr(8'h03, 8'h01);
        exp_reg(8'h03, 8'h00, "R4 bit0 only");
        wr(8'h03, 8'h82);

        // R5 disabled source ignored, enabled source flags
        pulse(8'h40, 1);
        exp_reg(8'h04, 8'h00, "R5 disabled source");
        exp_irq(1'b1, "R5 disabled irq");
        pulse(8'h02, 1);
        exp_reg(8'h04, 8'h02, "R5 sat flag");
        exp_irq(1'b0, "R5 irq low");
        exp_reg(8'h01, 8'h01, "R2 one event");

        // R10 read-only counters, unmapped read
        wr(8'h01, 8'h55);
        exp_reg(8'h01, 8'h01, "R10 sat write ignored");
        wr(8'h02, 8'h33);
        exp_reg(8'h02, 8'h00, "R10 par write ignored");
        exp_reg(8'h07, 8'h00, "R10 unmapped read");

        // R6 write 0 no effect; R7 other bit leaves counter
        wr(8'h04, 8'h00);
        exp_reg(8'h04, 8'h02, "R6 write zero");
        wr(8'h04, 8'h80);
        exp_reg(8'h04, 8'h02, "R6 other bit ack");
        exp_reg(8'h01, 8'h01, "R7 other bit keeps count");
        wr(8'h04, 8'h02);
        exp_reg(8'h04, 8'h00, "R6 ack clears");
        exp_reg(8'h01, 8'h00, "R7 sat cleared");
        exp_irq(1'b1, "R8 irq released");

        // R3 parity counter and R7 parity ack
        pulse(8'h80, 3);
        exp_reg(8'h02, 8'h03, "R3 three parity");
        exp_reg(8'h04, 8'h80, "R3 parity flag");
        wr(8'h04, 8'h80);
        exp_reg(8'h02, 8'h00, "R7 par cleared");
        exp_reg(8'h04, 8'h00, "R7 par flag cleared");

        // R2 saturation at 255
        pulse(8'h02, 250);
        exp_reg(8'h01, 8'd250, "R2 count 250");
        pulse(8'h02, 10);
        exp_reg(8'h01, 8'hFF, "R2 saturates");

        // R9 event wins against ack
        wr_with_evt(8'h04, 8'h02, 8'h02);
        exp_reg(8'h04, 8'h02, "R9 flag kept");
        exp_reg(8'h01, 8'h01, "R9 count restarts");
        exp_irq(1'b0, "R9 irq still low");

        // R8 masking releases irq, unmasking reasserts
        wr(8'h03, 8'h80);
        exp_irq(1'b1, "R8 masked");
        exp_reg(8'h04, 8'h02, "R8 flag retained");
        wr(8'h03, 8'h82);
        exp_irq(1'b0, "R8 unmasked");
        wr(8'h04, 8'hFF);
        exp_irq(1'b1, "R8 all cleared");

        // R5 remaining sources
        wr(8'h03, 8'h7C);
        pulse(8'h3C, 1);
        exp_reg(8'h04, 8'h3C, "R5 lock and param flags");
        pulse(8'h40, 1);
        exp_reg(8'h04, 8'h7C, "R5 self-test flag");
        wr(8'h04, 8'h7C);
        exp_irq(1'b1, "R8 released after ack");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule